// File: doc/BRIEF.md
# Log-domain to floating-point word converter

This block turns a logarithmic-format number into an ordinary binary floating-point word. The input holds a two-bit class code, a sign, a two's-complement integer part and an unsigned fraction part of the base-2 logarithm. The output has a sign, a biased exponent and a fraction with an implied leading one. Denormals are never produced. The class code selects zero, infinity or NaN directly. For finite values, the exponent is the log's integer part plus the bias, and the mantissa is two raised to the log's fraction.

The mantissa is not read from one large table. The log fraction is cut into equal fields. Each field addresses its own 16-entry table of powers of two, and the table outputs are multiplied in a short pipelined chain. The block takes one word per cycle and keeps a valid bit alongside the data. It is meant to sit at the boundary where a log-domain datapath hands results to floating-point logic.

Top module: `lns2fp_conv`

## Requirements
- R1: Input layout is `in_lns[23:22]` class (00 zero, 01 finite, 10 infinity, 11 NaN), `[21]` sign, `[20:12]` integer part (two's complement), `[11:0]` log fraction. Output layout is `out_fp[18]` sign, `[17:10]` exponent, `[9:0]` fraction. Class 00 gives exponent 0 and fraction 0.
- R2: Class 10 gives exponent 255 and fraction 0.
- R3: Class 11 gives exponent 255 and fraction 10'h200.
- R4: The output sign equals the input sign for every class.
- R5: For class 01, when the integer part plus 127 lies in 1..254, that sum is the output exponent.
- R6: For class 01, when the integer part plus 127 is 0 or below, the output is exponent 0 and fraction 0. This includes the most negative integer part, -256.
- R7: For class 01, when the integer part plus 127 is 255 or above, the output is exponent 255 and fraction 0.
- R8: The finite-class fraction is computed in four steps:
  - Split the log fraction into three 4-bit fields, from most to least significant. Field c with value j selects T_c[j] = round(2^(j/16^(c+1)) * 2048).
  - Set P = T_0.
  - Then, for c = 1 and c = 2, replace P with floor(P*T_c/2048), saturated to 4095.
  - The fraction is floor((P+1)/2) mod 1024. If floor((P+1)/2) reaches 2048, the fraction is instead all ones.
  
  As a result, 1 + fraction/1024 lies within 2/1024 of 2 raised to the log fraction.
- R9: Each input word with `in_valid` high yields exactly one output with `out_valid` high, 4 cycles later and in input order. One word is accepted per cycle.
- R10: While `rst_n` is low, `out_valid` and `out_fp` are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_lns | input | 24 | Log-format word: class, sign, integer part, log fraction |
| out_valid | output | 1 | Output word is present |
| out_fp | output | 19 | Floating-point word: sign, biased exponent, fraction |

## Verification
A misaligned table delay in the multiplier chain would combine fields from neighbouring words. Streams of back-to-back words with differing fractions would then show wrong fractions at the output four cycles later. A sideband pipeline out of step with the product chain would pair one word's class or exponent with another word's mantissa. It would also break the fixed four-cycle spacing between input and output valid. That shows up on the first stream of consecutive words. A wrong bias, or wrong range limits, appears as soon as the integer part crosses the 1 and 254 exponent boundaries.

// File: rtl/lns2fp_pkg.sv
// Shared types and constant helpers for the log-to-float converter.
// Assumes callers use the helper only at elaboration time (constant args).
package lns2fp_pkg;

    // Class code carried in the two top bits of the log-format word
    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NORM = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } lns_cls_e;

    // Returns round(2^(idx / 2^shift) * 2^frac_bits) as an integer table entry
    function automatic int exp2_entry(input int idx, input int shift, input int frac_bits);
        real x;
        real v;
        x = real'(idx) / (2.0 ** shift);
        v = (2.0 ** x) * (2.0 ** frac_bits);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/lns2fp_rom.sv
// Small power-of-two table for one field of the log fraction.
// Entry j holds 2^(j / 2^(CW*POS)) in Q1.(TW-1) format; contents are
// computed at elaboration. Assumes the value stays below 2.0.
module lns2fp_rom #(
    parameter int CW  = 4,
    parameter int TW  = 12,
    parameter int POS = 1
) (
    input  logic [CW-1:0] idx,
    output logic [TW-1:0] val
);
    localparam int N = 2 ** CW;

    logic [TW-1:0] tbl [N];

    // Fill each entry from the constant helper
    for (genvar j = 0; j < N; j++) begin : g_ent
        localparam logic [TW-1:0] ENT = TW'(lns2fp_pkg::exp2_entry(j, CW * POS, TW - 1));
        assign tbl[j] = ENT;
    end

    // Combinational read
    assign val = tbl[idx];

endmodule

// File: rtl/lns2fp_mulchain.sv
// Pipelined product of K table outputs, all in Q1.(TW-1) format.
// Table 0 is registered in stage 0. Table c is delayed c registers and
// multiplied in stage c. Each product is truncated back to TW bits and
// saturates to all ones if it reaches 2.0. Latency K cycles, K >= 2.
module lns2fp_mulchain #(
    parameter int K  = 3,
    parameter int TW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [K-1:0][TW-1:0]  tab_i,
    output logic [TW-1:0]         prod_o
);
    localparam logic [2*TW-1:0] MAXV = {{TW{1'b0}}, {TW{1'b1}}};

    for (genvar c = 0; c < K; c++) begin : g_st
        logic [TW-1:0] acc;
        if (c == 0) begin : g_first
            // Capture the first table output
            always_ff @(posedge clk) begin
                if (!rst_n) acc <= '0;
                else        acc <= tab_i[0];
            end
        end else begin : g_mul
            logic [TW-1:0]   dl [c];
            logic [2*TW-1:0] p;
            logic [2*TW-1:0] ps;
            logic [TW-1:0]   nxt;

            // Delay table c so it meets its partial product
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < c; i++) dl[i] <= '0;
                end else begin
                    dl[0] <= tab_i[c];
                    for (int i = 1; i < c; i++) dl[i] <= dl[i-1];
                end
            end

            // Multiply, rescale to Q1.(TW-1), saturate below 2.0
            always_comb begin
                p   = g_st[c-1].acc * dl[c-1];
                ps  = p >> (TW - 1);
                nxt = (ps > MAXV) ? {TW{1'b1}} : ps[TW-1:0];
            end

            // Register the partial product
            always_ff @(posedge clk) begin
                if (!rst_n) acc <= '0;
                else        acc <= nxt;
            end
        end
    end

    assign prod_o = g_st[K-1].acc;

endmodule

// File: rtl/lns2fp_pack.sv
// Assembles the floating-point word from class, sign, exponent and the
// Q1.(FRAC_W+1) mantissa product. Rounds half up to FRAC_W bits and
// clamps a round-up to 2.0 at all ones. Assumes the product is >= 1.0.
module lns2fp_pack
    import lns2fp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 10
) (
    input  lns_cls_e                   cls,
    input  logic                       sgn,
    input  logic [EXP_W-1:0]           ex,
    input  logic [FRAC_W+1:0]          prod,
    output logic [EXP_W+FRAC_W:0]      fp
);
    localparam logic [EXP_W-1:0]  EMAX    = {EXP_W{1'b1}};
    localparam logic [FRAC_W-1:0] NAN_FRC = FRAC_W'(1) << (FRAC_W - 1);

    logic [FRAC_W-1:0] frc;

    // Round the product to FRAC_W fraction bits with saturation
    always_comb begin
        if (&prod) frc = {FRAC_W{1'b1}};
        else       frc = prod[FRAC_W:1] + FRAC_W'(prod[0]);
    end

    // Select the encoding by class
    always_comb begin
        unique case (cls)
            CLS_ZERO: fp = {sgn, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
            CLS_INF:  fp = {sgn, EMAX, {FRAC_W{1'b0}}};
            CLS_NAN:  fp = {sgn, EMAX, NAN_FRC};
            default:  fp = {sgn, ex, frc};
        endcase
    end

endmodule

// File: rtl/lns2fp_conv.sv
// Log-format to floating-point converter, one word per cycle.
// Stage 0 decodes class and exponent range and reads the K field tables.
// Stages 1..K-1 multiply table outputs. The last stage rounds and packs.
// Latency K+1 cycles. Assumes LFRAC_W divisible by K and K >= 2.
module lns2fp_conv
    import lns2fp_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 10,
    parameter int INT_W   = 9,
    parameter int LFRAC_W = 12,
    parameter int K       = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [2+1+INT_W+LFRAC_W-1:0] in_lns,
    output logic                        out_valid,
    output logic [EXP_W+FRAC_W:0]       out_fp
);
    localparam int LNS_W = 2 + 1 + INT_W + LFRAC_W;
    localparam int FP_W  = 1 + EXP_W + FRAC_W;
    localparam int CW    = LFRAC_W / K;
    localparam int TW    = FRAC_W + 2;
    localparam int BW    = ((INT_W > EXP_W) ? INT_W : EXP_W) + 2;
    localparam int BIAS  = 2 ** (EXP_W - 1) - 1;
    localparam int EMAX  = 2 ** EXP_W - 1;
    localparam logic signed [BW-1:0] BIAS_S = BW'(BIAS);
    localparam logic signed [BW-1:0] EMAX_S = BW'(EMAX);

    typedef struct packed {
        logic             vld;
        lns_cls_e         cls;
        logic             sgn;
        logic [EXP_W-1:0] ex;
    } side_t;

    logic [1:0]                flg;
    logic                      sgn_in;
    logic [INT_W-1:0]          ipart;
    logic [LFRAC_W-1:0]        fpart;
    logic signed [BW-1:0]      biased;
    side_t                     side_nxt;
    side_t                     sb [K];
    logic [K-1:0][TW-1:0]      tabs;
    logic [TW-1:0]             prod;
    logic [FP_W-1:0]           fp_nxt;

    assign flg    = in_lns[LNS_W-1 -: 2];
    assign sgn_in = in_lns[INT_W+LFRAC_W];
    assign ipart  = in_lns[LFRAC_W +: INT_W];
    assign fpart  = in_lns[LFRAC_W-1:0];

    // Decode class and fold out-of-range exponents into zero or infinity
    always_comb begin
        biased       = $signed({{(BW-INT_W){ipart[INT_W-1]}}, ipart}) + BIAS_S;
        side_nxt.vld = in_valid;
        side_nxt.sgn = sgn_in;
        side_nxt.ex  = biased[EXP_W-1:0];
        side_nxt.cls = lns_cls_e'(flg);
        if (lns_cls_e'(flg) == CLS_NORM) begin
            if (biased <= $signed(BW'(0)))  side_nxt.cls = CLS_ZERO;
            else if (biased >= EMAX_S)      side_nxt.cls = CLS_INF;
        end
    end

    // One table per log-fraction field, most significant field first
    for (genvar c = 0; c < K; c++) begin : g_rom
        lns2fp_rom #(.CW(CW), .TW(TW), .POS(c + 1)) i_rom (
            .idx (fpart[LFRAC_W-1-c*CW -: CW]),
            .val (tabs[c])
        );
    end

    lns2fp_mulchain #(.K(K), .TW(TW)) i_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .tab_i  (tabs),
        .prod_o (prod)
    );

    // Carry class, sign, exponent and valid alongside the product chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < K; i++) sb[i] <= '0;
        end else begin
            sb[0] <= side_nxt;
            for (int i = 1; i < K; i++) sb[i] <= sb[i-1];
        end
    end

    lns2fp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_pack (
        .cls  (sb[K-1].cls),
        .sgn  (sb[K-1].sgn),
        .ex   (sb[K-1].ex),
        .prod (prod),
        .fp   (fp_nxt)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fp    <= '0;
        end else begin
            out_valid <= sb[K-1].vld;
            out_fp    <= fp_nxt;
        end
    end

endmodule

// File: rtl/lns2fp_conv_chk.sv
// Property checker for lns2fp_conv. It keeps its own delayed copy of the
// input class, sign and integer part and relates it to the output word.
module lns2fp_conv_chk #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 10,
    parameter int INT_W   = 9,
    parameter int LFRAC_W = 12,
    parameter int K       = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [2+1+INT_W+LFRAC_W-1:0] in_lns,
    input logic                         out_valid,
    input logic [EXP_W+FRAC_W:0]        out_fp
);
    localparam int LAT   = K + 1;
    localparam int LNS_W = 2 + 1 + INT_W + LFRAC_W;
    localparam int DW    = 2 + 1 + INT_W;
    localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};
    localparam logic [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};

    logic [LAT-1:0] vp;
    logic [DW-1:0]  dp [LAT];
    logic           dv;
    logic [1:0]     dflg;
    logic           dsgn;
    logic [INT_W-1:0] dint;
    logic             osgn;
    logic [EXP_W-1:0] oexp;
    logic [FRAC_W-1:0] ofrc;

    // Delay line matching the converter latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vp <= '0;
            for (int i = 0; i < LAT; i++) dp[i] <= '0;
        end else begin
            vp <= {vp[LAT-2:0], in_valid};
            dp[0] <= in_lns[LNS_W-1:LFRAC_W];
            for (int i = 1; i < LAT; i++) dp[i] <= dp[i-1];
        end
    end

    assign dv   = vp[LAT-1];
    assign dflg = dp[LAT-1][DW-1 -: 2];
    assign dsgn = dp[LAT-1][INT_W];
    assign dint = dp[LAT-1][INT_W-1:0];
    assign osgn = out_fp[EXP_W+FRAC_W];
    assign oexp = out_fp[FRAC_W +: EXP_W];
    assign ofrc = out_fp[FRAC_W-1:0];

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_fp == '0)); // R10
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == dv); // R9
    AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n) (dv && dflg == 2'b00) |-> (oexp == '0 && ofrc == '0)); // R1
    AST_INF_CLASS: assert property (@(posedge clk) disable iff (!rst_n) (dv && dflg == 2'b10) |-> (oexp == EMAX && ofrc == '0)); // R2
    AST_NAN_CLASS: assert property (@(posedge clk) disable iff (!rst_n) (dv && dflg == 2'b11) |-> (oexp == EMAX && ofrc != '0)); // R3
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n) dv |-> (osgn == dsgn)); // R4
    AST_MIN_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (dv && dflg == 2'b01 && dint == IMIN) |-> (oexp == '0 && ofrc == '0)); // R6
    AST_FINITE_NOT_NAN: assert property (@(posedge clk) disable iff (!rst_n) (dv && dflg == 2'b01) |-> !(oexp == EMAX && ofrc != '0)); // R7

endmodule

bind lns2fp_conv lns2fp_conv_chk #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .INT_W   (INT_W),
    .LFRAC_W (LFRAC_W),
    .K       (K)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_lns    (in_lns),
    .out_valid (out_valid),
    .out_fp    (out_fp)
);

// File: tb/test_lns2fp_conv.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes expected words, the monitor
// pops and compares them as results leave the converter.
module test_lns2fp_conv;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [23:0] in_lns;
    logic        out_valid;
    logic [18:0] out_fp;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [18:0] q_exp [$];
    string       q_tag [$];
    int          q_cyc [$];
    real         q_ref [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lns2fp_conv i_lns2fp_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lns(in_lns),
        .out_valid(out_valid), .out_fp(out_fp)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Table entry of R8
    function automatic int tent(input int c, input int j);
        return $rtoi((2.0 ** (real'(j) / (16.0 ** (c + 1)))) * 2048.0 + 0.5);
    endfunction

    // Fraction of R8
    function automatic logic [9:0] mant(input logic [11:0] f);
        int p;
        int r;
        p = tent(0, int'(f[11:8]));
        p = (p * tent(1, int'(f[7:4]))) / 2048;
        if (p > 4095) p = 4095;
        p = (p * tent(2, int'(f[3:0]))) / 2048;
        if (p > 4095) p = 4095;
        r = (p + 1) / 2;
        if (r >= 2048) return 10'h3ff;
        return 10'(r);
    endfunction

    // Expected word from R1..R8
    function automatic logic [18:0] model(input logic [23:0] w);
        int b;
        b = int'($signed(w[20:12])) + 127;
        case (w[23:22])
            2'b00:   return {w[21], 8'h00, 10'h000};
            2'b10:   return {w[21], 8'hff, 10'h000};
            2'b11:   return {w[21], 8'hff, 10'h200};
            default: begin
                if (b <= 0)   return {w[21], 8'h00, 10'h000};
                if (b >= 255) return {w[21], 8'hff, 10'h000};
                return {w[21], 8'(b), mant(w[11:0])};
            end
        endcase
    endfunction

    function automatic logic [23:0] mk(input logic [1:0] fl, input logic s, input int i, input logic [11:0] f);
        return {fl, s, 9'(i), f};
    endfunction

    // Driver: apply one word and push its expectation
    task automatic send(input logic [23:0] w, input string tag);
        logic [18:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        in_lns   = w;
        e = model(w);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        q_cyc.push_back(cyc);
        if (w[23:22] == 2'b01 && e[17:10] != 8'h00 && e[17:10] != 8'hff)
            q_ref.push_back(2.0 ** (real'(w[11:0]) / 4096.0));
        else
            q_ref.push_back(-1.0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_lns   = 24'h0;
        end
    endtask

    // Monitor: compare each result against the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_exp.size() == 0) begin
                chk(1'b0, "R9 unexpected output", 32'(out_fp), 32'h0);
            end else begin
                logic [18:0] e;
                string t;
                int c0;
                real rv;
                real got;
                e  = q_exp.pop_front();
                t  = q_tag.pop_front();
                c0 = q_cyc.pop_front();
                rv = q_ref.pop_front();
                chk(out_fp == e, t, 32'(out_fp), 32'(e));
                chk(cyc - c0 == 4, "R9 latency", 32'(cyc - c0), 32'd4);
                if (rv > 0.0) begin
                    got = 1.0 + real'(out_fp[9:0]) / 1024.0;
                    chk((got - rv < 2.0 / 1024.0) && (rv - got < 2.0 / 1024.0),
                        "R8 accuracy", 32'(out_fp[9:0]), 32'($rtoi((rv - 1.0) * 1024.0)));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_lns = mk(2'b01, 1'b0, 0, 12'h123);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R10 valid in reset", 32'(out_valid), 32'd0);
        chk(out_fp == '0, "R10 data in reset", 32'(out_fp), 32'd0);
        in_valid = 1'b0;
        in_lns = 24'h0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        send(mk(2'b00, 1'b0, 17, 12'habc), "R1 zero class");
        send(mk(2'b00, 1'b1, -3, 12'h001), "R1 R4 negative zero");
        send(mk(2'b10, 1'b0, 0, 12'h000), "R2 infinity");
        send(mk(2'b10, 1'b1, -200, 12'hfff), "R2 R4 negative infinity");
        send(mk(2'b11, 1'b0, 5, 12'h555), "R3 NaN");
        send(mk(2'b11, 1'b1, 0, 12'h000), "R3 R4 negative NaN");
        idle(3);
        send(mk(2'b01, 1'b0, 0, 12'h000), "R5 unity");
        send(mk(2'b01, 1'b1, 5, 12'h800), "R5 R4 exponent");
        send(mk(2'b01, 1'b0, -126, 12'h400), "R5 lowest exponent");
        send(mk(2'b01, 1'b0, 127, 12'hc00), "R5 highest exponent");
        send(mk(2'b01, 1'b0, -127, 12'h7ff), "R6 biased zero");
        send(mk(2'b01, 1'b1, -256, 12'h000), "R6 most negative integer");
        send(mk(2'b01, 1'b0, -200, 12'h333), "R6 deep underflow");
        send(mk(2'b01, 1'b0, 128, 12'h000), "R7 biased max");
        send(mk(2'b01, 1'b1, 255, 12'hfff), "R7 largest integer");
        idle(1);
        send(mk(2'b01, 1'b0, 1, 12'hfff), "R8 top fraction");
        send(mk(2'b01, 1'b0, 1, 12'h001), "R8 low field");
        send(mk(2'b01, 1'b0, 1, 12'h0f0), "R8 middle field");
        send(mk(2'b01, 1'b0, 1, 12'ha5a), "R8 mixed fields");
        send(mk(2'b01, 1'b0, 1, 12'hf00), "R8 high field");
        idle(2);
        for (int n = 0; n < 40; n++) begin
            logic [23:0] w;
            w = 24'($urandom);
            send(w, "R9 stream");
        end
        for (int n = 0; n < 20; n++) begin
            logic [23:0] w;
            w = mk(2'b01, 1'(n), (n * 13) % 300 - 150, 12'($urandom));
            send(w, "R8 R9 gapped stream");
            if (n % 3 == 0) idle(n % 4 + 1);
        end
        idle(10);
        chk(q_exp.size() == 0, "R9 all outputs seen", 32'(q_exp.size()), 32'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule